// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into an asynchronous serial frame on a single line. On an accepted load strobe it captures the data byte, the extra-bit value and every format control. It then sends a low start bit, 5 to 8 data bits least significant first, an optional extra bit, an optional parity bit and a high stop period. When the line is not sending, it sits high.

All timing comes from an external single-cycle tick that pulses at twice the bit rate. Each ordinary bit lasts two ticks. This lets the long stop period on 5-bit frames last one and a half bit times. A busy flag is high from the load until the frame ends. A single-cycle done pulse marks the cycle in which busy falls. Baud generation, queuing, register access and interrupts belong to the surrounding logic.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever busy is low, the serial line is high and done is low.
- R2: A frame starts with one low bit. The data bits follow, least significant first. Their count is set by the length code: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: With parity enabled, parity kind 0 (odd) makes the number of ones across the data bits and the parity bit odd. Kind 1 (even) makes that number even. The extra bit never enters the parity.
- R4: With parity enabled, parity kind 2 always sends a 1 and kind 3 always sends a 0.
- R5: With parity disabled, no parity bit is sent. The stop period follows directly after the data bits, or after the extra bit when that is enabled.
- R6: With extra-bit enable high, the extra-bit input value is sent right after the last data bit and before any parity bit.
- R7: With the stop-length control low, the line stays high for one bit time (two ticks) before busy falls.
- R8: With the stop-length control high, the stop period is two bit times (four ticks) for 6-, 7- or 8-bit data, and one and a half bit times (three ticks) for 5-bit data.
- R9: Each start, data, extra and parity bit lasts exactly two ticks. The line changes only on a tick, or on the accepted load.
- R10: Data and format are captured when a load is accepted while idle. A load strobe while busy, and changes to the inputs during a frame, have no effect on the frame being sent.
- R11: Done is high for exactly one cycle, in the cycle in which busy falls at the end of the stop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a frame when idle |
| tx_data | input | 8 | Character to send |
| extra_val | input | 1 | Value of the appended extra bit |
| half_tick | input | 1 | Single-cycle pulse at twice the bit rate |
| len_code | input | 2 | Data length code (0..3 for 5..8 bits) |
| par_on | input | 1 | Parity enable |
| par_kind | input | 2 | Parity kind: 0 odd, 1 even, 2 mark, 3 space |
| extra_on | input | 1 | Extra-bit enable |
| stop_long | input | 1 | Long stop period select |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong bit counter or frame length shows up at the ports as an extra or missing half-bit sample before busy falls, within one frame. A wrong parity, extra-bit position or shift order corrupts a specific tick sample inside the same frame. A stop counter loaded with the wrong value moves the done pulse by one or more ticks, so it shows as a wrong sample count. A frame that captures its inputs at the wrong moment shows as a corrupted sample once a mid-frame load or input change is applied.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int DATA_MAX = 8;
    localparam int FRAME_W  = DATA_MAX + 3;   // start + data + extra + parity
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int STOP_W   = 3;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_on;
        logic [1:0] par_kind;
        logic       extra_on;
        logic       stop_long;
    } fmt_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BITS = 2'd1,
        ST_STOP = 2'd2
    } tx_state_t;

    function automatic logic [CNT_W-1:0] data_count(input logic [1:0] code);
        return CNT_W'(5) + CNT_W'(code);
    endfunction

    function automatic logic parity_of(input logic [DATA_MAX-1:0] d,
                                       input logic [1:0] code,
                                       input logic [1:0] kind);
        logic [DATA_MAX-1:0] masked;
        masked = d & (8'hFF >> (2'd3 - code));
        case (kind)
            2'd0:    return ~(^masked);
            2'd1:    return ^masked;
            2'd2:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [STOP_W-1:0] stop_halves(input logic [1:0] code,
                                                      input logic lng);
        if (!lng)           return STOP_W'(2);
        else if (code == 0) return STOP_W'(3);
        else                return STOP_W'(4);
    endfunction

endpackage

// File: rtl/uft_framer.sv
module uft_framer
    import uft_pkg::*;
(
    input  logic [DATA_MAX-1:0] data,
    input  logic                extra_val,
    input  fmt_t                fmt,
    output logic [FRAME_W-1:0]  frame,
    output logic [CNT_W-1:0]    nbits,
    output logic [STOP_W-1:0]   nstop
);
    logic [CNT_W-1:0] dlen;

    always_comb begin
        logic [CNT_W-1:0] pos;
        dlen  = data_count(fmt.len_code);
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (CNT_W'(i) < dlen) frame[i+1] = data[i];
        end
        pos = dlen + CNT_W'(1);
        if (fmt.extra_on) begin
            frame[pos] = extra_val;
            pos = pos + CNT_W'(1);
        end
        if (fmt.par_on) begin
            frame[pos] = parity_of(data, fmt.len_code, fmt.par_kind);
            pos = pos + CNT_W'(1);
        end
        nbits = pos;
        nstop = stop_halves(fmt.len_code, fmt.stop_long);
    end

    always_comb begin
        AST_FRAME_LEN: assert (nbits >= CNT_W'(6) && nbits <= CNT_W'(FRAME_W)); // R2
        AST_START_LOW: assert (frame[0] == 1'b0); // R2
    end

endmodule

// File: rtl/uft_shifter.sv
module uft_shifter
    import uft_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               tick,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    input  logic [STOP_W-1:0]  nstop,
    output logic               txd,
    output logic               busy,
    output logic               done
);
    tx_state_t          state;
    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   bits_left;
    logic [STOP_W-1:0]  stop_left;
    logic               second_half;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            sh          <= '1;
            bits_left   <= '0;
            stop_left   <= '0;
            second_half <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    sh          <= frame;
                    bits_left   <= nbits;
                    stop_left   <= nstop;
                    second_half <= 1'b0;
                    state       <= ST_BITS;
                end
                ST_BITS: if (tick) begin
                    second_half <= ~second_half;
                    if (second_half) begin
                        sh <= {1'b1, sh[FRAME_W-1:1]};
                        if (bits_left == CNT_W'(1)) state <= ST_STOP;
                        else bits_left <= bits_left - CNT_W'(1);
                    end
                end
                ST_STOP: if (tick) begin
                    if (stop_left == STOP_W'(1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        stop_left <= stop_left - STOP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign txd  = (state == ST_BITS) ? sh[0] : 1'b1;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (txd && !$past(busy) |-> !done)); // R1
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |-> txd); // R7
    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !$past(tick)) |-> $stable(txd)); // R9
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R11
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && !$past(tick)) |-> busy); // R10

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uft_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] tx_data,
    input  logic       extra_val,
    input  logic       half_tick,
    input  logic [1:0] len_code,
    input  logic       par_on,
    input  logic [1:0] par_kind,
    input  logic       extra_on,
    input  logic       stop_long,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    fmt_t               fmt;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    logic [STOP_W-1:0]  nstop;
    logic               accept;

    assign fmt = '{len_code: len_code, par_on: par_on, par_kind: par_kind,
                   extra_on: extra_on, stop_long: stop_long};
    assign accept = load && !busy;

    uft_framer u_framer (
        .data      (tx_data),
        .extra_val (extra_val),
        .fmt       (fmt),
        .frame     (frame),
        .nbits     (nbits),
        .nstop     (nstop)
    );

    uft_shifter u_shifter (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .tick  (half_tick),
        .frame (frame),
        .nbits (nbits),
        .nstop (nstop),
        .txd   (txd),
        .busy  (busy),
        .done  (done)
    );

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && !txd)); // R2

endmodule

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       extra_val = 1'b0;
    logic       half_tick = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic       par_on = 1'b0;
    logic [1:0] par_kind = 2'd0;
    logic       extra_on = 1'b0;
    logic       stop_long = 1'b0;
    logic       txd, busy, done;

    int checks = 0;
    int errors = 0;
    logic rec [0:31];
    logic exp_bits [0:31];

    uart_frame_tx u0 (
        .clk(clk), .rst(rst), .load(load), .tx_data(tx_data),
        .extra_val(extra_val), .half_tick(half_tick), .len_code(len_code),
        .par_on(par_on), .par_kind(par_kind), .extra_on(extra_on),
        .stop_long(stop_long), .txd(txd), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            half_tick <= 1'b1;
            @(posedge clk);
            half_tick <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Sends one frame and compares every tick sample with a frame built from the requirements.
    task automatic run_frame(input logic [7:0] d, input logic xv, input logic [1:0] lc,
                             input logic pe, input logic [1:0] pk, input logic xe,
                             input logic sl, input bit disturb, input string tag);
        int ne, n, dn, cyc, ones, dl, mism;
        logic pbit;
        dl = 5 + int'(lc);
        ne = 0; ones = 0;
        exp_bits[ne++] = 1'b0; exp_bits[ne++] = 1'b0;
        for (int i = 0; i < dl; i++) begin
            exp_bits[ne++] = d[i]; exp_bits[ne++] = d[i];
            if (d[i]) ones++;
        end
        if (xe) begin exp_bits[ne++] = xv; exp_bits[ne++] = xv; end
        if (pe) begin
            case (pk)
                2'd0: pbit = (ones % 2 == 0);
                2'd1: pbit = (ones % 2 == 1);
                2'd2: pbit = 1'b1;
                default: pbit = 1'b0;
            endcase
            exp_bits[ne++] = pbit; exp_bits[ne++] = pbit;
        end
        for (int i = 0; i < (!sl ? 2 : (lc == 0 ? 3 : 4)); i++) exp_bits[ne++] = 1'b1;

        @(negedge clk);
        tx_data <= d; extra_val <= xv; len_code <= lc; par_on <= pe;
        par_kind <= pk; extra_on <= xe; stop_long <= sl; load <= 1'b1;
        @(negedge clk);
        load <= 1'b0;
        n = 0; dn = 0; cyc = 0;
        forever begin
            if (done) dn++;
            if (!busy) break;
            if (half_tick && n < 32) rec[n++] = txd;
            cyc++;
            if (disturb && cyc == 20) begin
                load <= 1'b1; tx_data <= ~d; extra_val <= ~xv; len_code <= ~lc;
                par_on <= ~pe; par_kind <= ~pk; extra_on <= ~xe; stop_long <= ~sl;
            end
            if (disturb && cyc == 21) load <= 1'b0;
            if (cyc > 2000) break;
            @(negedge clk);
        end
        mism = -1;
        for (int i = 0; i < ne && i < n; i++) if (rec[i] !== exp_bits[i] && mism < 0) mism = i;
        chk(n == ne, {tag, " half-bit count"}, n, ne);
        chk(mism < 0, {tag, " first mismatching half-bit"}, mism, -1);
        chk(dn == 1, {tag, " R11 done seen as busy falls"}, dn, 1);
        @(negedge clk);
        chk(!done && txd && !busy, {tag, " R11 R1 done gone and line idle"}, {done, txd, busy}, 3'b010);
        load <= 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst <= 1'b0;
        @(negedge clk);
        chk(txd && !busy && !done, "R1 reset idle state", {txd, busy, done}, 3'b100);
        run_frame(8'hA5, 1'b0, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R2 R5 R7 R9 8-bit plain");
        run_frame(8'h16, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R8 5-bit long stop");
        run_frame(8'h2B, 1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R8 6-bit long stop");
        run_frame(8'hD3, 1'b0, 2'd2, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R3 7-bit odd");
        run_frame(8'h81, 1'b0, 2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, "R3 8-bit even");
        run_frame(8'hE0, 1'b0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R3 5-bit odd masked");
        run_frame(8'h00, 1'b0, 2'd3, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, "R4 mark");
        run_frame(8'hFF, 1'b0, 2'd3, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, "R4 space");
        run_frame(8'h35, 1'b1, 2'd3, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, "R6 R3 extra then even");
        run_frame(8'h0C, 1'b0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, "R6 R5 extra no parity");
        run_frame(8'h5A, 1'b1, 2'd2, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, "R10 load while busy");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule